// File: doc/BRIEF.md
# Release-on-acknowledge VME interrupter with retrigger

This block turns a single interrupt request from the on-chip bus side into a request on one of the seven active-low VME interrupt lines. A programmable level picks the line, and a programmable vector is returned to the interrupt handler. Once the handler acknowledges, the line is released at the acknowledge itself. This is release-on-acknowledge behaviour, so the on-chip source does not have to do anything to drop the VME line.

During an acknowledge cycle the block sits in the acknowledge daisy chain. A cycle counts as an acknowledge cycle when IACK is low at the moment AS falls. The block then waits for its daisy-chain input. If it holds a pending request at the level being acknowledged, it takes the cycle: it drives the vector, clears its pending flag and pulses an acknowledge output for one clock. If it does not, it passes the chain on through IACKOUT until AS is released.

A source may still be requesting after it has been serviced, because the driver acknowledged the VME interrupt but never cleared the cause. In that case a retry timer re-raises the interrupt once per retry period, which is 1 ms by default. The period in cycles is the retry time divided by the clock period, both given as parameters. All bus inputs are expected to be synchronized to the clock already.

Top module: `vme_roak_irq`

## Requirements
- R1: A low-to-high change of `int_req_i` that is seen at a clock edge, with nothing pending and a non-zero level, drives the selected line low from that edge on. "Selected" means that `irq_n_o` bit (level-1) carries IRQ(level).
- R2: After reset, and at any time the level is 0, all of `irq_n_o` are high. After reset `iackout_n_o` is high and `vec_oe_o` and `ack_pulse_o` are low.
- R3: At most one interrupt line is low at a time, and it is the one for the current level. Level 7 uses bit 6.
- R4: In an acknowledge cycle, IACKIN may be seen low while a request is pending and `ack_level_i` equals the level. On the edge that sees this, the vector drive turns on with `vec_data_o` equal to `irq_vector_i`, the interrupt line goes high, and `ack_pulse_o` is high for exactly one cycle.
- R5: In an acknowledge cycle where nothing is pending, or where the levels differ, `iackout_n_o` goes low on the edge that sees IACKIN low. The vector is not driven, and a pending request stays pending.
- R6: The vector drive and the low `iackout_n_o` last until AS goes high. Both are removed on the next edge.
- R7: If IACK is high when AS falls, the cycle is ignored: neither the vector nor IACKOUT responds, even when IACKIN is low.
- R8: A request held high through an acknowledge raises the line again RETRY_NS/CLK_PERIOD_NS cycles after the acknowledge edge, and not earlier.
- R9: A request that drops before the retry period ends produces no further interrupt.
- R10: A second rising edge while a request is pending adds nothing. A single acknowledge clears the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_req_i | input | 1 | Interrupt request from the on-chip source |
| irq_level_i | input | 3 | Line to use, 0 disables; must not change while pending |
| irq_vector_i | input | 8 | Vector returned when the acknowledge is taken |
| as_n_i | input | 1 | Synchronized address strobe, active low |
| iack_n_i | input | 1 | Synchronized acknowledge-cycle flag, active low |
| iackin_n_i | input | 1 | Synchronized daisy-chain input, active low |
| ack_level_i | input | 3 | Level being acknowledged, from the address lines |
| irq_n_o | output | 7 | Interrupt lines, bit k is IRQ(k+1), active low |
| iackout_n_o | output | 1 | Daisy-chain output, active low |
| vec_oe_o | output | 1 | Drive enable for the vector |
| vec_data_o | output | 8 | Vector value |
| ack_pulse_o | output | 1 | One-cycle pulse when the interrupt is acknowledged |

## Verification
Some properties are checked by assertions on every cycle:
- At most one line is low, and none is low at level 0.
- The acknowledge pulse never lasts past one cycle.
- The vector drive and IACKOUT never respond together, and both drop the cycle after AS rises.
- A qualified rising edge always sets the pending flag.
- The retry timer is cleared whenever the request is low.

The rest can only be shown by the bench's scenarios:
- The choice between taking the cycle and passing it on, for matching and mismatching levels.
- Keeping a pending request through a passed cycle.
- Ignoring cycles that are not acknowledge cycles.
- The exact timing of the retrigger window.

// File: rtl/vme_roak_irq_pkg.sv
package vme_roak_irq_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_WAIT = 2'd1,
    ACK_TAKE = 2'd2,
    ACK_PASS = 2'd3
  } ack_state_t;

endpackage

// File: rtl/irq_issue.sv
module irq_issue #(
  parameter int RETRY_CYCLES = 100000,
  parameter int LVL_W        = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             grant_i,
  output logic             pending_o
);

  localparam int CNT_W = (RETRY_CYCLES > 2) ? $clog2(RETRY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_CYCLES - 1);

  logic             req_q;
  logic             pending_q, pending_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             rise, held, fire, issue;

  always_comb begin
    rise  = req_i & ~req_q;
    held  = req_i & req_q;
    fire  = held & ~grant_i & (cnt_q == CNT_LAST);
    issue = rise | fire;

    if (!held || grant_i || fire) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end

    if (grant_i) begin
      pending_d = 1'b0;
    end else if (issue && (level_i != '0)) begin
      pending_d = 1'b1;
    end else begin
      pending_d = pending_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= 1'b0;
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else begin
      req_q     <= req_i;
      pending_q <= pending_d;
      cnt_q     <= cnt_d;
    end
  end

  assign pending_o = pending_q;

  // R1: a qualified rising edge always leaves a pending request
  a_r1_edge_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !req_q && !pending_q && (level_i != '0)) |=> pending_q);

  // R9: the retry timer is idle whenever the request is low
  a_r9_timer_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (cnt_q == '0));

endmodule

// File: rtl/iack_responder.sv
module iack_responder
  import vme_roak_irq_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             as_n_i,
  input  logic             iack_n_i,
  input  logic             iackin_n_i,
  input  logic [LVL_W-1:0] ack_level_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             pending_i,
  input  logic [VEC_W-1:0] vector_i,
  output logic             grant_o,
  output logic             vec_oe_o,
  output logic [VEC_W-1:0] vec_data_o,
  output logic             iackout_n_o,
  output logic             ack_pulse_o
);

  ack_state_t       state_q, state_d;
  logic             as_q;
  logic             ack_q;
  logic [VEC_W-1:0] vec_q;
  logic             as_fall, chain_in, match, grant;

  always_comb begin
    as_fall  = as_q & ~as_n_i;
    chain_in = (state_q == ACK_WAIT) & ~as_n_i & ~iackin_n_i;
    match    = pending_i & (level_i != '0) & (ack_level_i == level_i);
    grant    = chain_in & match;
    state_d  = state_q;
    unique case (state_q)
      ACK_IDLE: if (as_fall && !iack_n_i) state_d = ACK_WAIT;
      ACK_WAIT: begin
        if (as_n_i)        state_d = ACK_IDLE;
        else if (chain_in) state_d = match ? ACK_TAKE : ACK_PASS;
      end
      ACK_TAKE: if (as_n_i) state_d = ACK_IDLE;
      ACK_PASS: if (as_n_i) state_d = ACK_IDLE;
      default:  state_d = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACK_IDLE;
      as_q    <= 1'b1;
      ack_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      as_q    <= as_n_i;
      ack_q   <= grant;
      if (grant) begin
        vec_q <= vector_i;
      end
    end
  end

  assign grant_o     = grant;
  assign vec_oe_o    = (state_q == ACK_TAKE);
  assign vec_data_o  = vec_q;
  assign iackout_n_o = (state_q != ACK_PASS);
  assign ack_pulse_o = ack_q;

  // R4: the acknowledge pulse lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_pulse_o |=> !ack_pulse_o);

  // R5: taking the cycle and passing it on never happen together
  a_r5_take_or_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_oe_o && !iackout_n_o));

  // R6: both responses are gone the cycle after AS rises
  a_r6_release_on_as: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_n_i |=> (iackout_n_o && !vec_oe_o));

endmodule

// File: rtl/vme_roak_irq.sv
module vme_roak_irq #(
  parameter int NUM_IRQ       = 7,
  parameter int VEC_W         = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int RETRY_NS      = 1000000,
  parameter int LVL_W         = $clog2(NUM_IRQ + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               int_req_i,
  input  logic [LVL_W-1:0]   irq_level_i,
  input  logic [VEC_W-1:0]   irq_vector_i,
  input  logic               as_n_i,
  input  logic               iack_n_i,
  input  logic               iackin_n_i,
  input  logic [LVL_W-1:0]   ack_level_i,
  output logic [NUM_IRQ-1:0] irq_n_o,
  output logic               iackout_n_o,
  output logic               vec_oe_o,
  output logic [VEC_W-1:0]   vec_data_o,
  output logic               ack_pulse_o
);

  localparam int RETRY_CYCLES = RETRY_NS / CLK_PERIOD_NS;

  logic pending;
  logic grant;

  irq_issue #(
    .RETRY_CYCLES (RETRY_CYCLES),
    .LVL_W        (LVL_W)
  ) u_issue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (int_req_i),
    .level_i   (irq_level_i),
    .grant_i   (grant),
    .pending_o (pending)
  );

  iack_responder #(
    .LVL_W (LVL_W),
    .VEC_W (VEC_W)
  ) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .as_n_i      (as_n_i),
    .iack_n_i    (iack_n_i),
    .iackin_n_i  (iackin_n_i),
    .ack_level_i (ack_level_i),
    .level_i     (irq_level_i),
    .pending_i   (pending),
    .vector_i    (irq_vector_i),
    .grant_o     (grant),
    .vec_oe_o    (vec_oe_o),
    .vec_data_o  (vec_data_o),
    .iackout_n_o (iackout_n_o),
    .ack_pulse_o (ack_pulse_o)
  );

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    assign irq_n_o[k] = ~(pending && (irq_level_i == LVL_W'(k + 1)));
  end

  // R3: never more than one line pulled low
  a_r3_single_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~irq_n_o));

  // R2: level 0 keeps every line released
  a_r2_level_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_i == '0) |-> (&irq_n_o));

endmodule

// File: tb/vme_roak_irq_tb.sv
module vme_roak_irq_tb;

  localparam int R = 200;  // RETRY_NS 2000 / 10 ns

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req;
  logic [2:0] lvl;
  logic [7:0] vec;
  logic       as_n, iack_n, iackin_n;
  logic [2:0] alvl;
  logic [6:0] irq_n;
  logic       iackout_n, vec_oe, ack;
  logic [7:0] vec_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vme_roak_irq #(.CLK_PERIOD_NS(10), .RETRY_NS(2000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .int_req_i(req), .irq_level_i(lvl),
    .irq_vector_i(vec), .as_n_i(as_n), .iack_n_i(iack_n),
    .iackin_n_i(iackin_n), .ack_level_i(alvl), .irq_n_o(irq_n),
    .iackout_n_o(iackout_n), .vec_oe_o(vec_oe), .vec_data_o(vec_data),
    .ack_pulse_o(ack)
  );

  function automatic logic [6:0] exp_lines(input logic [2:0] l, input bit pend);
    if (!pend || l == 3'd0) return 7'h7F;
    return ~(7'b1 << (l - 3'd1));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one acknowledge cycle; ends two negedges after the deciding edge
  task automatic iack_cycle(input logic [2:0] al, input bit take, input logic [7:0] v,
                            input logic [6:0] lines_after);
    as_n = 1'b0; iack_n = 1'b0; alvl = al;
    tick(1);
    iackin_n = 1'b0;
    tick(1);
    if (take) begin
      chk("R4 vec_oe", vec_oe, 1);
      chk("R4 vec_data", vec_data, v);
      chk("R4 ack pulse", ack, 1);
      chk("R4 line released", irq_n, 7'h7F);
      chk("R5 no iackout on take", iackout_n, 1);
    end else begin
      chk("R5 iackout", iackout_n, 0);
      chk("R5 no vector", vec_oe, 0);
      chk("R5 no ack", ack, 0);
      chk("R5 still pending", irq_n, lines_after);
    end
    tick(1);
    chk("R4 pulse one cycle", ack, 0);
    chk("R6 held until AS", take ? vec_oe : !iackout_n, 1);
    as_n = 1'b1; iack_n = 1'b1; iackin_n = 1'b1;
    tick(1);
    chk("R6 released vec", vec_oe, 0);
    chk("R6 released iackout", iackout_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; req = 0; lvl = 0; vec = 0;
    as_n = 1; iack_n = 1; iackin_n = 1; alvl = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R2 reset lines", irq_n, 7'h7F);
    chk("R2 reset iackout", iackout_n, 1);
    chk("R2 reset vec_oe", vec_oe, 0);
    chk("R2 reset ack", ack, 0);

    // R2: level 0 disables
    req = 1; tick(2);
    chk("R2 level0 no line", irq_n, 7'h7F);
    req = 0; tick(1);

    // R7: non-acknowledge cycle ignored
    lvl = 3'd3; vec = 8'hA5; req = 1; tick(1);
    chk("R1 line on edge", irq_n, exp_lines(3, 1));
    as_n = 0; iack_n = 1; tick(1);
    iack_n = 0; iackin_n = 0; tick(2);
    chk("R7 no vector", vec_oe, 0);
    chk("R7 no iackout", iackout_n, 1);
    chk("R7 line kept", irq_n, exp_lines(3, 1));
    as_n = 1; iack_n = 1; iackin_n = 1; tick(1);

    // R10: extra rising edge while pending
    req = 0; tick(1); req = 1; tick(1);
    chk("R10 still one line", irq_n, exp_lines(3, 1));

    // R8: request held through acknowledge, retrigger window
    iack_cycle(3'd3, 1, 8'hA5, 7'h7F);
    tick(R - 4);
    chk("R8 no early retrigger", irq_n, 7'h7F);
    tick(3);
    chk("R8 retriggered", irq_n, exp_lines(3, 1));
    req = 0;
    iack_cycle(3'd3, 1, 8'hA5, 7'h7F);

    // R9: request dropped before the period
    lvl = 3'd7; vec = 8'h3C; req = 1; tick(1);
    chk("R3 level7 bit6", irq_n, 7'h3F);
    iack_cycle(3'd7, 1, 8'h3C, 7'h7F);
    req = 0;
    tick(R + 10);
    chk("R9 no retrigger", irq_n, 7'h7F);

    // R5: nothing pending gets passed on
    iack_cycle(3'd2, 0, 8'h00, 7'h7F);

    // random mix
    for (int i = 0; i < 16; i++) begin
      logic [2:0] l;
      logic [7:0] v;
      bit miss;
      l = 3'(1 + $urandom_range(6));
      v = 8'($urandom);
      miss = 1'($urandom_range(1));
      lvl = l; vec = v; req = 0; tick(1);
      req = 1; tick(1);
      chk("R1 R3 random line", irq_n, exp_lines(l, 1));
      if (miss) iack_cycle(3'((l % 7) + 1), 0, v, exp_lines(l, 1));
      iack_cycle(l, 1, v, 7'h7F);
      req = 0; tick(1);
      chk("R10 cleared after one ack", irq_n, 7'h7F);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule